// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block produces the hazard control for a five-stage in-order pipeline (IF, ID, EX, MEM, WB) with 32-bit registers. The decoder sends it the fields of the instruction in ID: its source specifiers, a flag for each source it reads, its destination, and whether it writes, loads, branches on equality or jumps. The block keeps its own shadow copy of these fields as they move through ID/EX, EX/MEM and MEM/WB. From that copy it chooses the forwarding source for the two EX-stage ALU operands and for the two ID-stage equality comparator operands.

Two cases need a stall, because no forwarding path can deliver the value yet. One is a value still being loaded. The other is a branch operand still being computed. During a stall the block raises `stall_o`, which tells the surrounding pipeline to hold the PC and IF/ID, and `bubble_o`, which tells it to put a nop into ID/EX. Both jump and beq resolve in ID. The block computes the redirect select and the target. The instruction after a branch or jump is a delay slot, and that slot always executes.

The register file is taken to be write-through: a value written in WB is seen by a read in ID during the same cycle.

Top module: `hzd_unit`

## Requirements
- R1: Forwarding select codes are 0 for register file or ID/EX value, 1 for EX/MEM ALU result, and 2 for MEM/WB result. An EX operand selects 1 when EX/MEM holds a non-load write to its source register. It selects 2 when MEM/WB holds a write to that register. Otherwise it selects 0.
- R2: When both EX/MEM and MEM/WB write the same source register, the select is 1, because EX/MEM holds the younger value.
- R3: Register 0 never causes a forward or a stall. A write to register 0 is recorded as no write.
- R4: When an instruction in ID reads a register that the load in EX is writing, there is exactly one stall cycle. Once the consumer reaches EX, its operand selects 2.
- R5: While `stall_o` is high, `bubble_o` is high and `pc_sel_o` is low. The bubble placed in ID/EX carries no write, so no later forward comes from it.
- R6: The ID comparator operands use the same select codes as R1. A beq that reads the result of the ALU instruction just before it stalls one cycle, then selects 1.
- R7: A beq that reads the result of the load just before it stalls two cycles, then selects 2.
- R8: A jump never stalls, even when a load in EX is writing a register it names. It sets `pc_sel_o`, and `target_o` equals the 15-bit jump field.
- R9: A beq that is not stalled sets `pc_sel_o` exactly when `id_eq_i` is high. Its target is `id_pc_i + 1 + id_imm_i`, where the immediate is two's complement and the sum wraps at 15 bits. A beq that is not taken leaves `pc_sel_o` low.
- R10: No flush is ever generated. The instruction in the delay slot after a taken beq proceeds with no stall and no redirect of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_rs_i | input | 5 | First source specifier of the ID instruction |
| id_rt_i | input | 5 | Second source specifier of the ID instruction |
| id_use_rs_i | input | 1 | The ID instruction reads its first source |
| id_use_rt_i | input | 1 | The ID instruction reads its second source |
| id_dst_i | input | 5 | Destination specifier of the ID instruction |
| id_wr_i | input | 1 | The ID instruction writes a register |
| id_load_i | input | 1 | The ID instruction is a load |
| id_beq_i | input | 1 | The ID instruction is beq |
| id_jump_i | input | 1 | The ID instruction is jump |
| id_eq_i | input | 1 | The forwarded comparator operands are equal |
| id_pc_i | input | 15 | Word address of the ID instruction |
| id_imm_i | input | 15 | Branch offset, or jump target |
| id_fwd_a_o | output | 2 | Source select for comparator operand A |
| id_fwd_b_o | output | 2 | Source select for comparator operand B |
| ex_fwd_a_o | output | 2 | Source select for ALU operand A |
| ex_fwd_b_o | output | 2 | Source select for ALU operand B |
| stall_o | output | 1 | Hold the PC and IF/ID |
| bubble_o | output | 1 | Load a nop into ID/EX |
| pc_sel_o | output | 1 | Take the redirect target |
| target_o | output | 15 | Redirect target address |

## Verification
Some properties are checked on every cycle. A jump never stalls, and a redirect never coincides with a stall. A stall always leaves a non-writing bubble in EX. No stall lasts longer than two cycles. A redirect other than a jump needs an equal beq. A register 0 source never forwards in EX. Other behaviour can only be shown by the bench's instruction sequences. These include the exact stall counts for load-use and the two beq cases. They also include the select chosen once the stall ends, EX/MEM priority over MEM/WB, the wrapped branch target, and the delay slot moving through untouched.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'd0,
    FWD_EXMEM = 2'd1,
    FWD_MEMWB = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/hzd_shadow_pipe.sv
module hzd_shadow_pipe #(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_use_rs_i,
  input  logic          id_use_rt_i,
  input  logic [AW-1:0] id_dst_i,
  input  logic          id_wr_i,
  input  logic          id_load_i,
  output logic [AW-1:0] ex_rs_o,
  output logic [AW-1:0] ex_rt_o,
  output logic          ex_use_rs_o,
  output logic          ex_use_rt_o,
  output logic [AW-1:0] ex_dst_o,
  output logic          ex_wr_o,
  output logic          ex_load_o,
  output logic [AW-1:0] mem_dst_o,
  output logic          mem_wr_o,
  output logic          mem_load_o,
  output logic [AW-1:0] wb_dst_o,
  output logic          wb_wr_o
);
  logic id_wr_eff;
  // writes to register 0 are dropped at entry
  assign id_wr_eff = id_wr_i && (id_dst_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_rs_o     <= '0;
      ex_rt_o     <= '0;
      ex_use_rs_o <= 1'b0;
      ex_use_rt_o <= 1'b0;
      ex_dst_o    <= '0;
      ex_wr_o     <= 1'b0;
      ex_load_o   <= 1'b0;
    end else if (stall_i) begin
      ex_rs_o     <= '0;
      ex_rt_o     <= '0;
      ex_use_rs_o <= 1'b0;
      ex_use_rt_o <= 1'b0;
      ex_dst_o    <= '0;
      ex_wr_o     <= 1'b0;
      ex_load_o   <= 1'b0;
    end else begin
      ex_rs_o     <= id_rs_i;
      ex_rt_o     <= id_rt_i;
      ex_use_rs_o <= id_use_rs_i;
      ex_use_rt_o <= id_use_rt_i;
      ex_dst_o    <= id_dst_i;
      ex_wr_o     <= id_wr_eff;
      ex_load_o   <= id_load_i && id_wr_eff;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_dst_o  <= '0;
      mem_wr_o   <= 1'b0;
      mem_load_o <= 1'b0;
      wb_dst_o   <= '0;
      wb_wr_o    <= 1'b0;
    end else begin
      mem_dst_o  <= ex_dst_o;
      mem_wr_o   <= ex_wr_o;
      mem_load_o <= ex_load_o;
      wb_dst_o   <= mem_dst_o;
      wb_wr_o    <= mem_wr_o;
    end
  end
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          used_i,
  input  logic [AW-1:0] near_dst_i,
  input  logic          near_wr_i,
  input  logic          near_load_i,
  input  logic [AW-1:0] far_dst_i,
  input  logic          far_wr_i,
  output fwd_src_e      sel_o
);
  logic live, near_hit, far_hit;

  assign live     = used_i && (src_i != '0);
  // load data is not ready in EX/MEM; the stall logic covers that case
  assign near_hit = live && near_wr_i && !near_load_i && (near_dst_i == src_i);
  assign far_hit  = live && far_wr_i && (far_dst_i == src_i);

  always_comb begin
    if (near_hit)     sel_o = FWD_EXMEM;
    else if (far_hit) sel_o = FWD_MEMWB;
    else              sel_o = FWD_RF;
  end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl #(
  parameter int AW = 5,
  parameter int TW = 15
) (
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_use_rs_i,
  input  logic          id_use_rt_i,
  input  logic          id_beq_i,
  input  logic          id_jump_i,
  input  logic          id_eq_i,
  input  logic [TW-1:0] id_pc_i,
  input  logic [TW-1:0] id_imm_i,
  input  logic [AW-1:0] ex_dst_i,
  input  logic          ex_wr_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_dst_i,
  input  logic          mem_wr_i,
  input  logic          mem_load_i,
  output logic          stall_o,
  output logic          pc_sel_o,
  output logic [TW-1:0] target_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  function automatic logic hit(input logic [AW-1:0] src, input logic used,
                               input logic [AW-1:0] dst, input logic wr);
    return used && (src != '0) && wr && (dst == src);
  endfunction

  logic dep_ex, dep_mem, load_use, beq_wait;

  assign dep_ex  = hit(id_rs_i, id_use_rs_i, ex_dst_i, ex_wr_i) ||
                   hit(id_rt_i, id_use_rt_i, ex_dst_i, ex_wr_i);
  assign dep_mem = hit(id_rs_i, id_use_rs_i, mem_dst_i, mem_wr_i) ||
                   hit(id_rt_i, id_use_rt_i, mem_dst_i, mem_wr_i);

  assign load_use = ex_load_i && dep_ex;
  // comparator in ID needs the value one stage earlier than the ALU would
  assign beq_wait = id_beq_i && (dep_ex || (mem_load_i && dep_mem));

  assign stall_o  = !id_jump_i && (load_use || beq_wait);
  assign pc_sel_o = id_jump_i || (id_beq_i && id_eq_i && !stall_o);
  assign target_o = id_jump_i ? id_imm_i : (id_pc_i + ONE + id_imm_i);
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int TGT_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs_i,
  input  logic [REG_AW-1:0] id_rt_i,
  input  logic              id_use_rs_i,
  input  logic              id_use_rt_i,
  input  logic [REG_AW-1:0] id_dst_i,
  input  logic              id_wr_i,
  input  logic              id_load_i,
  input  logic              id_beq_i,
  input  logic              id_jump_i,
  input  logic              id_eq_i,
  input  logic [TGT_W-1:0]  id_pc_i,
  input  logic [TGT_W-1:0]  id_imm_i,
  output logic [1:0]        id_fwd_a_o,
  output logic [1:0]        id_fwd_b_o,
  output logic [1:0]        ex_fwd_a_o,
  output logic [1:0]        ex_fwd_b_o,
  output logic              stall_o,
  output logic              bubble_o,
  output logic              pc_sel_o,
  output logic [TGT_W-1:0]  target_o
);
  localparam int NOPS = 2;

  logic [REG_AW-1:0] ex_rs_q, ex_rt_q, ex_dst_q, mem_dst_q, wb_dst_q;
  logic ex_use_rs_q, ex_use_rt_q, ex_wr_q, ex_load_q;
  logic mem_wr_q, mem_load_q, wb_wr_q;
  logic stall;

  hzd_shadow_pipe #(.AW(REG_AW)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall),
    .id_rs_i     (id_rs_i),
    .id_rt_i     (id_rt_i),
    .id_use_rs_i (id_use_rs_i),
    .id_use_rt_i (id_use_rt_i),
    .id_dst_i    (id_dst_i),
    .id_wr_i     (id_wr_i),
    .id_load_i   (id_load_i),
    .ex_rs_o     (ex_rs_q),
    .ex_rt_o     (ex_rt_q),
    .ex_use_rs_o (ex_use_rs_q),
    .ex_use_rt_o (ex_use_rt_q),
    .ex_dst_o    (ex_dst_q),
    .ex_wr_o     (ex_wr_q),
    .ex_load_o   (ex_load_q),
    .mem_dst_o   (mem_dst_q),
    .mem_wr_o    (mem_wr_q),
    .mem_load_o  (mem_load_q),
    .wb_dst_o    (wb_dst_q),
    .wb_wr_o     (wb_wr_q)
  );

  logic [REG_AW-1:0] id_src  [NOPS];
  logic              id_used [NOPS];
  logic [REG_AW-1:0] ex_src  [NOPS];
  logic              ex_used [NOPS];
  fwd_src_e          id_sel  [NOPS];
  fwd_src_e          ex_sel  [NOPS];

  assign id_src[0]  = id_rs_i;
  assign id_src[1]  = id_rt_i;
  assign id_used[0] = id_use_rs_i;
  assign id_used[1] = id_use_rt_i;
  assign ex_src[0]  = ex_rs_q;
  assign ex_src[1]  = ex_rt_q;
  assign ex_used[0] = ex_use_rs_q;
  assign ex_used[1] = ex_use_rt_q;

  // ID comparator sees producers one stage further along than EX does
  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    hzd_fwd_sel #(.AW(REG_AW)) u_id_sel (
      .src_i       (id_src[g]),
      .used_i      (id_used[g]),
      .near_dst_i  (mem_dst_q),
      .near_wr_i   (mem_wr_q),
      .near_load_i (mem_load_q),
      .far_dst_i   (wb_dst_q),
      .far_wr_i    (wb_wr_q),
      .sel_o       (id_sel[g])
    );
    hzd_fwd_sel #(.AW(REG_AW)) u_ex_sel (
      .src_i       (ex_src[g]),
      .used_i      (ex_used[g]),
      .near_dst_i  (mem_dst_q),
      .near_wr_i   (mem_wr_q),
      .near_load_i (mem_load_q),
      .far_dst_i   (wb_dst_q),
      .far_wr_i    (wb_wr_q),
      .sel_o       (ex_sel[g])
    );
  end

  assign id_fwd_a_o = id_sel[0];
  assign id_fwd_b_o = id_sel[1];
  assign ex_fwd_a_o = ex_sel[0];
  assign ex_fwd_b_o = ex_sel[1];

  hzd_stall_ctl #(.AW(REG_AW), .TW(TGT_W)) u_ctl (
    .id_rs_i     (id_rs_i),
    .id_rt_i     (id_rt_i),
    .id_use_rs_i (id_use_rs_i),
    .id_use_rt_i (id_use_rt_i),
    .id_beq_i    (id_beq_i),
    .id_jump_i   (id_jump_i),
    .id_eq_i     (id_eq_i),
    .id_pc_i     (id_pc_i),
    .id_imm_i    (id_imm_i),
    .ex_dst_i    (ex_dst_q),
    .ex_wr_i     (ex_wr_q),
    .ex_load_i   (ex_load_q),
    .mem_dst_i   (mem_dst_q),
    .mem_wr_i    (mem_wr_q),
    .mem_load_i  (mem_load_q),
    .stall_o     (stall),
    .pc_sel_o    (pc_sel_o),
    .target_o    (target_o)
  );

  assign stall_o  = stall;
  assign bubble_o = stall;
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          id_jump_i,
  input logic          id_beq_i,
  input logic          id_eq_i,
  input logic          stall_o,
  input logic          pc_sel_o,
  input logic          ex_wr_q,
  input logic          ex_use_rs_q,
  input logic [AW-1:0] ex_rs_q,
  input logic [1:0]    ex_fwd_a_o
);
  assert_jump_nostall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_jump_i |-> !stall_o);

  assert_stall_noredirect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !pc_sel_o);

  assert_bubble_nowrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !ex_wr_q);

  assert_stall_max_two_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && $past(stall_o)) |=> !stall_o);

  assert_redirect_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_sel_o && !id_jump_i) |-> (id_beq_i && id_eq_i));

  assert_reg0_nofwd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_use_rs_q && ex_rs_q == '0) |-> (ex_fwd_a_o == 2'd0));
endmodule

bind hzd_unit hzd_unit_chk #(.AW(REG_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .id_jump_i   (id_jump_i),
  .id_beq_i    (id_beq_i),
  .id_eq_i     (id_eq_i),
  .stall_o     (stall_o),
  .pc_sel_o    (pc_sel_o),
  .ex_wr_q     (ex_wr_q),
  .ex_use_rs_q (ex_use_rs_q),
  .ex_rs_q     (ex_rs_q),
  .ex_fwd_a_o  (ex_fwd_a_o)
);

// File: tb/hzd_unit_bench.sv
module hzd_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  rs, rt, dst;
  logic        urs, urt, wr, ld, beq, jmp, eq;
  logic [14:0] pc, imm;
  logic [1:0]  ia, ib, ea, eb;
  logic        stall, bubble, psel;
  logic [14:0] tgt;

  hzd_unit u_hzd_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs_i(rs), .id_rt_i(rt), .id_use_rs_i(urs), .id_use_rt_i(urt),
    .id_dst_i(dst), .id_wr_i(wr), .id_load_i(ld), .id_beq_i(beq),
    .id_jump_i(jmp), .id_eq_i(eq), .id_pc_i(pc), .id_imm_i(imm),
    .id_fwd_a_o(ia), .id_fwd_b_o(ib), .ex_fwd_a_o(ea), .ex_fwd_b_o(eb),
    .stall_o(stall), .bubble_o(bubble), .pc_sel_o(psel), .target_o(tgt)
  );

  typedef struct {
    logic        st;
    logic        ps;
    logic        ct;
    logic [14:0] tg;
    logic [1:0]  ia, ib, ea, eb;
    string       req;
  } exp_t;

  exp_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compares combinational outputs mid-cycle
  always @(negedge clk) begin
    #3;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, "stall", stall, e.st);
      chk(e.req, "bubble", bubble, e.st);
      chk(e.req, "pc_sel", psel, e.ps);
      if (e.ct) chk(e.req, "target", tgt, e.tg);
      chk(e.req, "id_fwd_a", ia, e.ia);
      chk(e.req, "id_fwd_b", ib, e.ib);
      chk(e.req, "ex_fwd_a", ea, e.ea);
      chk(e.req, "ex_fwd_b", eb, e.eb);
    end
  end

  // driver: one ID instruction per cycle with expected outputs
  task automatic step(
    input logic [4:0] i_rs, input logic [4:0] i_rt, input logic i_urs, input logic i_urt,
    input logic [4:0] i_dst, input logic i_wr, input logic i_ld,
    input logic i_beq, input logic i_jmp, input logic i_eq,
    input logic [14:0] i_pc, input logic [14:0] i_imm,
    input logic x_st, input logic x_ps, input logic x_ct, input logic [14:0] x_tg,
    input logic [1:0] x_ia, input logic [1:0] x_ib, input logic [1:0] x_ea, input logic [1:0] x_eb,
    input string req);
    exp_t e;
    @(negedge clk);
    rs = i_rs; rt = i_rt; urs = i_urs; urt = i_urt; dst = i_dst; wr = i_wr; ld = i_ld;
    beq = i_beq; jmp = i_jmp; eq = i_eq; pc = i_pc; imm = i_imm;
    e.st = x_st; e.ps = x_ps; e.ct = x_ct; e.tg = x_tg;
    e.ia = x_ia; e.ib = x_ib; e.ea = x_ea; e.eb = x_eb; e.req = req;
    sb.push_back(e);
  endtask

  task automatic nop(input string req);
    step(0,0,0,0, 0,0,0, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, req);
  endtask

  initial begin
    rs = 0; rt = 0; urs = 0; urt = 0; dst = 0; wr = 0; ld = 0;
    beq = 0; jmp = 0; eq = 0; pc = 0; imm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nop("reset");
    // R4 load-use: lw r1; add r2=r1+r3
    step(0,0,1,0, 1,1,1, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R4");
    step(1,3,1,1, 2,1,0, 0,0,0, 0,0, 1,0,0,0, 0,0,0,0, "R4");
    step(1,3,1,1, 2,1,0, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R4");
    step(0,0,0,0, 0,0,0, 0,0,0, 0,0, 0,0,0,0, 0,0,2,0, "R4");
    nop("R5");
    // R1/R2: add r4; add r4=r4; sub r7=r4-r4
    step(5,6,1,1, 4,1,0, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R1");
    step(4,0,1,1, 4,1,0, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R1");
    step(4,4,1,1, 7,1,0, 0,0,0, 0,0, 0,0,0,0, 1,1,1,0, "R1");
    step(0,0,0,0, 0,0,0, 0,0,0, 0,0, 0,0,0,0, 0,0,1,1, "R2");
    nop("R1");
    // R3: writes to r0 neither forward nor stall
    step(1,0,1,0, 0,1,0, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R3");
    step(0,0,1,1, 8,1,0, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R3");
    nop("R3");
    step(0,0,1,0, 0,1,1, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R3");
    step(0,0,1,1, 9,1,0, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R3");
    nop("R3");
    nop("R3");
    // R6: add r10; beq r10,r11 -> one stall then EX/MEM
    step(1,2,1,1, 10,1,0, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R6");
    step(10,11,1,1, 0,0,0, 1,0,1, 100,5, 1,0,1,106, 0,0,0,0, "R6");
    step(10,11,1,1, 0,0,0, 1,0,1, 100,5, 0,1,1,106, 1,0,0,0, "R9");
    // R10: delay slot proceeds
    step(10,0,1,0, 12,1,0, 0,0,0, 0,0, 0,0,0,0, 2,0,2,0, "R10");
    // R7: lw r13; beq r13,r0 -> two stalls then MEM/WB
    step(0,0,1,0, 13,1,1, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R7");
    step(13,0,1,1, 0,0,0, 1,0,1, 200,15'h7FFD, 1,0,1,198, 0,0,0,0, "R7");
    step(13,0,1,1, 0,0,0, 1,0,1, 200,15'h7FFD, 1,0,1,198, 0,0,0,0, "R7");
    step(13,0,1,1, 0,0,0, 1,0,1, 200,15'h7FFD, 0,1,1,198, 2,0,0,0, "R9");
    // R8: jump behind a load never stalls
    step(0,0,1,0, 14,1,1, 0,0,0, 0,0, 0,0,0,0, 0,0,0,0, "R8");
    step(14,0,1,0, 0,0,0, 0,1,0, 0,15'h1234, 0,1,1,15'h1234, 0,0,0,0, "R8");
    // R9: beq not taken
    step(1,2,1,1, 0,0,0, 1,0,0, 300,10, 0,0,1,311, 0,0,0,0, "R9");
    nop("R10");
    @(negedge clk);
    #5;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule